// File: doc/BRIEF.md
# Inbound Descriptor-Chain DMA Engine

This block is the receive side of one DMA channel. A peripheral hands it a stream of bytes, each beat marked as the final byte of a packet or not. The engine places each byte in memory at the position held by its saved buffer pointer. That position comes from the data descriptor currently loaded, which the engine reads from memory as four 32-bit words:

| Offset | Content |
|--------|---------|
| +0 | next descriptor address |
| +4 | buffer start |
| +8 | buffer end (exclusive) |
| +12 | flag word |

In the flag word, bit 0 is end-of-list, bit 1 requests an interrupt, bit 2 is reserved for the transmit direction and is kept unchanged, and bit 3 records a received packet end.

A descriptor closes in two cases: its buffer becomes full, or a packet ends inside it. On close, the engine does the following in order:

1. It writes the real fill point into the buffer-end word.
2. It writes the flag word back, with bit 3 set if a packet end caused the close.
3. It updates a raw interrupt vector.

After that, the engine either fetches the descriptor named by the next field, or, when end-of-list is set, writes a disable word to the channel context and parks. A start pulse carries a descriptor address and a context address. It restarts the channel from the idle state or from the parked state.

Top module: `inb_dma_engine`

## Requirements
- R1: After reset, s_ready, mem_req, o_eol, o_irq, o_irq_raw and o_desc_close are all 0.
- R2: A start pulse in the idle or parked state reads the four descriptor words at the given address (next at +0, buffer at +4, end at +8, flags at +12), loads the saved pointer with the buffer word, reports the address on o_cur_desc, and then raises s_ready.
- R3: Each accepted byte is written as one memory write to the saved pointer. The write uses byte enable bit addr[1:0], with the byte copied to all four lanes. The saved pointer then advances by exactly one.
- R4: When the saved pointer reaches the buffer end without a packet end, the descriptor closes with flag bit 3 clear. Bytes that follow go into the next descriptor.
- R5: A byte with s_last set closes the descriptor after it is written. The buffer-end word is rewritten with the saved pointer, flag bit 3 is set in the written-back flag word, and raw interrupt bit 3 is set.
- R6: On any close of a descriptor whose flag bit 1 is set, raw interrupt bits 0 and 1 are set.
- R7: o_irq is recomputed as the OR of (raw AND i_irq_mask) only in a cycle where the raw vector changes. A change of the mask alone leaves o_irq as it was. Each bit set in i_irq_ack clears the matching raw bit, and a set in the same cycle takes priority over the clear.
- R8: Closing a descriptor whose flag bit 0 is set writes the value 1 to the context address, sets o_eol, and stops. While o_eol is 1, s_ready stays 0 and no byte is taken.
- R9: Closing a descriptor whose flag bit 0 is clear fetches the descriptor at its next field. s_ready is 0 throughout every descriptor read and write-back.
- R10: A descriptor whose buffer start equals its buffer end closes as soon as its fetch completes, without taking a byte, and flag bit 3 stays clear.
- R11: A start pulse clears o_eol in the cycle that follows it.
- R12: o_desc_close pulses for one cycle on every descriptor close.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_start | input | 1 | Start pulse |
| i_desc_addr | input | ADDR_W | First descriptor address, taken on start |
| i_ctx_addr | input | ADDR_W | Context word address, taken on start |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Byte ends a packet |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_be | output | DATA_W/8 | Byte enables |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | DATA_W | Read data, valid with mem_ack |
| i_irq_mask | input | IRQ_W | Interrupt mask |
| i_irq_ack | input | IRQ_W | Raw interrupt clear, one bit per flag |
| o_irq | output | 1 | Interrupt line |
| o_irq_raw | output | IRQ_W | Raw interrupt vector |
| o_saved_buf | output | ADDR_W | Saved buffer pointer |
| o_cur_desc | output | ADDR_W | Current descriptor address |
| o_eol | output | 1 | Channel parked at end of list |
| o_desc_close | output | 1 | One-cycle pulse per descriptor close |

## Verification
The bench builds the engine with ADDR_W set to 16 and the default 32-bit data word and 4-bit interrupt vector. This keeps the whole descriptor chain, its buffers and the context word inside a 1 KB model memory, so that every written-back word and byte can be read back directly. The model memory completes a request only on every other cycle. This stretches each fetch and write-back, which puts the refusal of stream bytes during descriptor traffic within reach. A three-descriptor chain is arranged so that one chunk spans a full-buffer close, and the final byte hits a packet end and a full buffer at the same time.

// File: rtl/inb_dma_pkg.sv
// Shared constants and the controller state type for the inbound DMA engine.
// Assumes a four-word descriptor and a flag word whose bit positions are
// decoded by software and by the outbound engine, so they are fixed here.
package inb_dma_pkg;

    localparam int DESC_WORDS = 4;
    localparam int W_NEXT     = 0;
    localparam int W_BUF      = 1;
    localparam int W_END      = 2;
    localparam int W_FLAGS    = 3;

    localparam int FLG_EOL    = 0;
    localparam int FLG_INTR   = 1;
    localparam int FLG_OEOP   = 2;
    localparam int FLG_IEOP   = 3;

    localparam int IRQ_DONE0  = 0;
    localparam int IRQ_DONE1  = 1;
    localparam int IRQ_PKT    = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RUN,
        ST_WRITE,
        ST_WB_END,
        ST_WB_FLAGS,
        ST_WB_CTX,
        ST_EOL
    } inb_state_e;

endpackage

// File: rtl/inb_lane_steer.sv
// Places one byte on the lane picked by the low address bits.
// Assumes a little-endian word of BYTES lanes; the byte is copied to every
// lane and only the selected enable is raised.
module inb_lane_steer #(
    parameter int BYTES = 4,
    localparam int SEL_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic [SEL_W-1:0]   lane_sel,
    input  logic [7:0]         byte_in,
    output logic [BYTES-1:0]   be,
    output logic [BYTES*8-1:0] wdata
);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        // Copy the byte to this lane and enable it only when selected.
        assign wdata[g*8 +: 8] = byte_in;
        assign be[g]           = (lane_sel == SEL_W'(g));
    end

endmodule

// File: rtl/inb_irq_ctrl.sv
// Raw interrupt vector with per-bit clear and a registered interrupt line.
// The line is recomputed only in cycles where the raw vector changes;
// a mask change by itself waits for the next raw change.
module inb_irq_ctrl #(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set_vec,
    input  logic [IRQ_W-1:0] ack_vec,
    input  logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] raw,
    output logic             irq
);

    logic [IRQ_W-1:0] raw_nx;

    // Next raw vector: clear acknowledged bits, then set wins.
    always_comb begin
        raw_nx = (raw & ~ack_vec) | set_vec;
    end

    // Hold the raw vector and refresh the line only when the vector moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw <= '0;
            irq <= 1'b0;
        end else if (raw_nx != raw) begin
            raw <= raw_nx;
            irq <= |(raw_nx & mask);
        end
    end

endmodule

// File: rtl/inb_desc_fsm.sv
// Descriptor walker and byte mover for the inbound channel.
// Fetches a descriptor, takes stream bytes one at a time into the buffer,
// closes on full buffer or packet end, writes the end word and flag word
// back, then follows the chain or parks after writing the context disable.
// Assumes the memory returns read data in the cycle it acknowledges.
module inb_desc_fsm
    import inb_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_desc,
    input  logic [ADDR_W-1:0] start_ctx,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    output logic              req,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              wr_byte,
    output logic [7:0]        byte_out,
    input  logic              ack,
    input  logic [DATA_W-1:0] rdata,
    output logic              close_pulse,
    output logic              close_intr,
    output logic              close_eop,
    output logic [ADDR_W-1:0] saved_buf,
    output logic [ADDR_W-1:0] cur_desc,
    output logic              eol
);

    localparam int IDX_W = $clog2(DESC_WORDS);

    inb_state_e        state;
    logic [IDX_W-1:0]  fidx;
    logic [ADDR_W-1:0] desc_q, ctx_q, next_q, buf_q, end_q, saved_q;
    logic [DATA_W-1:0] flags_q;
    logic [7:0]        byte_q;
    logic              last_q;
    logic              eop_q;

    logic              fetch_done, byte_done, buf_full, empty_desc;

    // Descriptor word address from the word index.
    function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                    input int idx);
        return base + ADDR_W'(idx * BYTES);
    endfunction

    // Completion and close conditions seen by the sequencer and the irq logic.
    always_comb begin
        fetch_done  = (state == ST_FETCH) && ack && (fidx == IDX_W'(W_FLAGS));
        byte_done   = (state == ST_WRITE) && ack;
        buf_full    = (saved_q + ADDR_W'(1)) == end_q;
        empty_desc  = (buf_q == end_q);
        close_pulse = (fetch_done && empty_desc) || (byte_done && (buf_full || last_q));
        close_intr  = fetch_done ? rdata[FLG_INTR] : flags_q[FLG_INTR];
        close_eop   = byte_done && last_q;
    end

    // Memory request decode per state.
    always_comb begin
        req     = 1'b0;
        we      = 1'b0;
        wr_byte = 1'b0;
        addr    = '0;
        wdata   = '0;
        unique case (state)
            ST_FETCH: begin
                req  = 1'b1;
                addr = word_addr(desc_q, int'(fidx));
            end
            ST_WRITE: begin
                req     = 1'b1;
                we      = 1'b1;
                wr_byte = 1'b1;
                addr    = saved_q;
            end
            ST_WB_END: begin
                req   = 1'b1;
                we    = 1'b1;
                addr  = word_addr(desc_q, W_END);
                wdata = DATA_W'(saved_q);
            end
            ST_WB_FLAGS: begin
                req   = 1'b1;
                we    = 1'b1;
                addr  = word_addr(desc_q, W_FLAGS);
                wdata = flags_q | (DATA_W'(eop_q) << FLG_IEOP);
            end
            ST_WB_CTX: begin
                req   = 1'b1;
                we    = 1'b1;
                addr  = ctx_q;
                wdata = DATA_W'(1);
            end
            default: ;
        endcase
    end

    // Sequencer: start, fetch, byte transfer, write-back and chaining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            fidx    <= '0;
            desc_q  <= '0;
            ctx_q   <= '0;
            next_q  <= '0;
            buf_q   <= '0;
            end_q   <= '0;
            saved_q <= '0;
            flags_q <= '0;
            byte_q  <= '0;
            last_q  <= 1'b0;
            eop_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_EOL: begin
                    if (start) begin
                        desc_q <= start_desc;
                        ctx_q  <= start_ctx;
                        fidx   <= '0;
                        state  <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (ack) begin
                        unique case (int'(fidx))
                            W_NEXT:  next_q  <= rdata[ADDR_W-1:0];
                            W_BUF:   buf_q   <= rdata[ADDR_W-1:0];
                            W_END:   end_q   <= rdata[ADDR_W-1:0];
                            default: flags_q <= rdata;
                        endcase
                        fidx <= fidx + IDX_W'(1);
                        if (fetch_done) begin
                            saved_q <= buf_q;
                            eop_q   <= 1'b0;
                            state   <= empty_desc ? ST_WB_END : ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (s_valid) begin
                        byte_q <= s_data;
                        last_q <= s_last;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (ack) begin
                        saved_q <= saved_q + ADDR_W'(1);
                        if (buf_full || last_q) begin
                            eop_q <= last_q;
                            state <= ST_WB_END;
                        end else begin
                            state <= ST_RUN;
                        end
                    end
                end
                ST_WB_END: begin
                    if (ack) state <= ST_WB_FLAGS;
                end
                ST_WB_FLAGS: begin
                    if (ack) begin
                        if (flags_q[FLG_EOL]) begin
                            state <= ST_WB_CTX;
                        end else begin
                            desc_q <= next_q;
                            fidx   <= '0;
                            state  <= ST_FETCH;
                        end
                    end
                end
                ST_WB_CTX: begin
                    if (ack) state <= ST_EOL;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign s_ready   = (state == ST_RUN);
    assign byte_out  = byte_q;
    assign saved_buf = saved_q;
    assign cur_desc  = desc_q;
    assign eol       = (state == ST_EOL);

endmodule

// File: rtl/inb_dma_engine.sv
// Top of the inbound DMA channel: sequencer, byte lane steering and the
// interrupt vector. Assumes DATA_W is a multiple of 8 and not narrower
// than ADDR_W, and IRQ_W covers the highest interrupt bit used.
module inb_dma_engine
    import inb_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IRQ_W  = 4,
    localparam int BYTES = DATA_W / 8,
    localparam int SEL_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_start,
    input  logic [ADDR_W-1:0] i_desc_addr,
    input  logic [ADDR_W-1:0] i_ctx_addr,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [BYTES-1:0]  mem_be,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [IRQ_W-1:0]  i_irq_mask,
    input  logic [IRQ_W-1:0]  i_irq_ack,
    output logic              o_irq,
    output logic [IRQ_W-1:0]  o_irq_raw,
    output logic [ADDR_W-1:0] o_saved_buf,
    output logic [ADDR_W-1:0] o_cur_desc,
    output logic              o_eol,
    output logic              o_desc_close
);

    logic              f_we, f_wr_byte;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_wdata;
    logic [7:0]        f_byte;
    logic              c_pulse, c_intr, c_eop;
    logic [BYTES-1:0]  l_be;
    logic [DATA_W-1:0] l_wdata;
    logic [IRQ_W-1:0]  irq_set;

    inb_desc_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (i_start),
        .start_desc  (i_desc_addr),
        .start_ctx   (i_ctx_addr),
        .s_valid     (s_valid),
        .s_ready     (s_ready),
        .s_data      (s_data),
        .s_last      (s_last),
        .req         (mem_req),
        .we          (f_we),
        .addr        (f_addr),
        .wdata       (f_wdata),
        .wr_byte     (f_wr_byte),
        .byte_out    (f_byte),
        .ack         (mem_ack),
        .rdata       (mem_rdata),
        .close_pulse (c_pulse),
        .close_intr  (c_intr),
        .close_eop   (c_eop),
        .saved_buf   (o_saved_buf),
        .cur_desc    (o_cur_desc),
        .eol         (o_eol)
    );

    inb_lane_steer #(
        .BYTES (BYTES)
    ) u_lane (
        .lane_sel (f_addr[SEL_W-1:0]),
        .byte_in  (f_byte),
        .be       (l_be),
        .wdata    (l_wdata)
    );

    // Build the raw interrupt set vector from the close event.
    always_comb begin
        irq_set            = '0;
        irq_set[IRQ_DONE0] = c_pulse && c_intr;
        irq_set[IRQ_DONE1] = c_pulse && c_intr;
        irq_set[IRQ_PKT]   = c_pulse && c_eop;
    end

    inb_irq_ctrl #(
        .IRQ_W (IRQ_W)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (irq_set),
        .ack_vec (i_irq_ack),
        .mask    (i_irq_mask),
        .raw     (o_irq_raw),
        .irq     (o_irq)
    );

    // Pick byte-lane or whole-word data for the memory port.
    always_comb begin
        mem_we    = f_we;
        mem_addr  = f_addr;
        mem_be    = f_wr_byte ? l_be : '1;
        mem_wdata = f_wr_byte ? l_wdata : f_wdata;
    end

    assign o_desc_close = c_pulse;

endmodule

// File: rtl/inb_dma_engine_chk.sv
// Protocol checker for the inbound DMA engine, attached by bind.
module inb_dma_engine_chk #(
    parameter int ADDR_W = 32,
    parameter int BYTES  = 4,
    parameter int IRQ_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_valid,
    input logic              s_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BYTES-1:0]  mem_be,
    input logic [ADDR_W-1:0] o_saved_buf,
    input logic              o_irq,
    input logic [IRQ_W-1:0]  o_irq_raw,
    input logic              o_eol
);

    AST_NO_READY_AT_EOL: assert property (@(posedge clk) disable iff (!rst_n)
        o_eol |-> !s_ready); // R8

    AST_BYTE_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (mem_req && mem_we && mem_be != '1)); // R3

    AST_SINGLE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != '1) |-> $onehot0(mem_be)); // R3

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && mem_be != '1)
        |=> (o_saved_buf == $past(mem_addr) + ADDR_W'(1))); // R3

    AST_NO_READY_DURING_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_be == '1) |-> !s_ready); // R9

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(o_irq_raw) |-> $stable(o_irq)); // R7

endmodule

bind inb_dma_engine inb_dma_engine_chk #(
    .ADDR_W (ADDR_W),
    .BYTES  (BYTES),
    .IRQ_W  (IRQ_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_valid     (s_valid),
    .s_ready     (s_ready),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .o_saved_buf (o_saved_buf),
    .o_irq       (o_irq),
    .o_irq_raw   (o_irq_raw),
    .o_eol       (o_eol)
);

// File: tb/test_inb_dma_engine.sv
module test_inb_dma_engine;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int IW = 4;
    localparam int NB = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          i_start = 1'b0;
    logic [AW-1:0] i_desc_addr = '0;
    logic [AW-1:0] i_ctx_addr = '0;
    logic          s_valid = 1'b0;
    logic          s_ready;
    logic [7:0]    s_data = '0;
    logic          s_last = 1'b0;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [NB-1:0] mem_be;
    logic [IW-1:0] i_irq_mask = '0;
    logic [IW-1:0] i_irq_ack = '0;
    logic          o_irq;
    logic [IW-1:0] o_irq_raw;
    logic [AW-1:0] o_saved_buf, o_cur_desc;
    logic          o_eol, o_desc_close;

    int n_tests = 0;
    int n_fail  = 0;
    int n_close = 0;
    int byte_idx = 0;
    logic ack_en = 1'b0;
    logic [31:0] mem [256];

    always #10 clk = ~clk;

    inb_dma_engine #(.ADDR_W(AW), .DATA_W(DW), .IRQ_W(IW)) i_inb_dma_engine (
        .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_desc_addr(i_desc_addr),
        .i_ctx_addr(i_ctx_addr), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_last(s_last), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .i_irq_mask(i_irq_mask),
        .i_irq_ack(i_irq_ack), .o_irq(o_irq), .o_irq_raw(o_irq_raw),
        .o_saved_buf(o_saved_buf), .o_cur_desc(o_cur_desc), .o_eol(o_eol),
        .o_desc_close(o_desc_close)
    );

    // Memory model: completes a request every other cycle.
    assign mem_ack   = mem_req && ack_en;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        ack_en <= ~ack_en;
        if (rst_n && o_desc_close) n_close <= n_close + 1;
        if (mem_req && mem_we && mem_ack)
            for (int b = 0; b < NB; b++)
                if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [AW-1:0] d, input logic [AW-1:0] c);
        @(negedge clk);
        i_start = 1'b1; i_desc_addr = d; i_ctx_addr = c;
        @(negedge clk);
        i_start = 1'b0;
    endtask

    task automatic send_chunk(input int n, input bit eop);
        for (int i = 0; i < n; i++) begin
            s_valid = 1'b1;
            s_data  = 8'hA0 + 8'(byte_idx);
            s_last  = eop && (i == n - 1);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            byte_idx++;
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic settle();
        for (int k = 0; k < 400; k++) begin
            if (s_ready || o_eol) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] mem_byte(input int a);
        return mem[a >> 2][(a % 4) * 8 +: 8];
    endfunction

    // {byte count, eop, expected saved pointer, expected descriptor}
    localparam int VN = 4;
    localparam logic [47:0] VEC [VN] = '{
        {8'd3,  8'd0, 16'h0103, 16'h0000},  // R3 partial fill
        {8'd2,  8'd1, 16'h0140, 16'h0010},  // R5 packet end, R9 chain
        {8'd6,  8'd0, 16'h0182, 16'h0020},  // R4 full close, leftover moves on
        {8'd14, 8'd1, 16'h0190, 16'h0020}   // R8 full and packet end, last in list
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // D0 at 0x000: intr
        mem[0] = 32'h010; mem[1] = 32'h100; mem[2] = 32'h108; mem[3] = 32'h2;
        // D1 at 0x010: no flags
        mem[4] = 32'h020; mem[5] = 32'h140; mem[6] = 32'h144; mem[7] = 32'h0;
        // D2 at 0x020: eol | intr
        mem[8] = 32'h000; mem[9] = 32'h180; mem[10] = 32'h190; mem[11] = 32'h3;
        // D3 at 0x030: empty buffer, eol
        mem[12] = 32'h000; mem[13] = 32'h1C0; mem[14] = 32'h1C0; mem[15] = 32'h1;

        repeat (3) @(negedge clk);
        chk("R1 s_ready", 32'(s_ready), 0);
        chk("R1 mem_req", 32'(mem_req), 0);
        chk("R1 eol", 32'(o_eol), 0);
        chk("R1 irq", 32'(o_irq), 0);
        chk("R1 raw", 32'(o_irq_raw), 0);
        chk("R12 close idle", 32'(o_desc_close), 0);
        @(negedge clk); rst_n = 1'b1;

        pulse_start(16'h0000, 16'h0040);
        chk("R9 ready low in fetch", 32'(s_ready), 0);
        settle();
        chk("R2 ready after fetch", 32'(s_ready), 1);
        chk("R2 saved = buf", 32'(o_saved_buf), 32'h100);
        chk("R2 cur desc", 32'(o_cur_desc), 32'h0);

        for (int v = 0; v < VN; v++) begin
            send_chunk(int'(VEC[v][47:40]), VEC[v][32]);
            settle();
            chk($sformatf("R3/R4/R5 vec%0d saved", v), 32'(o_saved_buf), 32'(VEC[v][31:16]));
            chk($sformatf("R9 vec%0d desc", v), 32'(o_cur_desc), 32'(VEC[v][15:0]));
            chk($sformatf("R8 vec%0d eol", v), 32'(o_eol), (v == VN - 1) ? 1 : 0);
        end

        chk("R5 D0 end word", mem[2], 32'h105);
        chk("R5 D0 flags", mem[3], 32'hA);
        chk("R4 D1 end word", mem[6], 32'h144);
        chk("R4 D1 flags", mem[7], 32'h0);
        chk("R5 D2 end word", mem[10], 32'h190);
        chk("R5 D2 flags", mem[11], 32'hB);
        chk("R8 context disable", mem[16], 32'h1);
        chk("R12 close count", 32'(n_close), 3);
        for (int a = 0; a < 5; a++)  chk("R3 D0 byte", 32'(mem_byte(16'h100 + a)), 32'(8'hA0 + a));
        for (int a = 0; a < 4; a++)  chk("R4 D1 byte", 32'(mem_byte(16'h140 + a)), 32'(8'hA5 + a));
        for (int a = 0; a < 16; a++) chk("R4 D2 byte", 32'(mem_byte(16'h180 + a)), 32'(8'hA9 + a));
        chk("R5 D0 tail untouched", 32'(mem_byte(16'h105)), 0);
        chk("R6 raw", 32'(o_irq_raw), 32'hB);
        chk("R7 masked off", 32'(o_irq), 0);

        // R8: input refused while parked
        s_valid = 1'b1; s_data = 8'h55;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (s_ready) chk("R8 ready while eol", 32'(s_ready), 0);
        end
        s_valid = 1'b0;
        chk("R8 saved unchanged", 32'(o_saved_buf), 32'h190);
        chk("R8 no byte stored", 32'(mem_byte(16'h190)), 0);

        // R7: mask change alone does not move the line
        i_irq_mask = 4'h1;
        repeat (4) @(negedge clk);
        chk("R7 mask alone", 32'(o_irq), 0);
        i_irq_ack = 4'h2;
        @(negedge clk);
        i_irq_ack = '0;
        chk("R7 ack clears bit", 32'(o_irq_raw), 32'h9);
        chk("R7 irq recomputed", 32'(o_irq), 1);
        i_irq_ack = 4'hF;
        @(negedge clk);
        i_irq_ack = '0;
        chk("R7 ack all raw", 32'(o_irq_raw), 0);
        chk("R7 ack all irq", 32'(o_irq), 0);

        // R10/R11: empty descriptor, restart from parked
        pulse_start(16'h0030, 16'h0044);
        chk("R11 eol cleared", 32'(o_eol), 0);
        settle();
        chk("R10 parked", 32'(o_eol), 1);
        chk("R10 saved", 32'(o_saved_buf), 32'h1C0);
        chk("R10 end word", mem[14], 32'h1C0);
        chk("R10 flags no eop", mem[15], 32'h1);
        chk("R10 ctx", mem[17], 32'h1);
        chk("R10 raw untouched", 32'(o_irq_raw), 0);
        chk("R12 close count", 32'(n_close), 4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule